// File: doc/BRIEF.md
# Junction Temperature Conversion Datapath

This block turns a stream of raw 12-bit thermal sensor codes into a calibrated junction temperature in millidegrees Celsius. It collects eight accepted codes and takes their integer mean. It then removes the sensor's curvature with a scaled integer division. A linear two-point calibration maps the result onto a temperature, which is finally rounded upward onto a 500 millidegree grid.

The two calibration points come from two 32-bit trim words. A word supplies its point only when its top bit marks it as programmed; otherwise a fixed default point is used. All three divisions share one sequential restoring divider. While a conversion is in flight the block reports itself busy and drops any code offered to it. A calibration pair that cannot define a slope produces an error pulse instead of a result.

Top module: `tj_convert`

## Requirements
- R1: Eight codes accepted while the block is not busy (`code_vld` high and `busy` low at a clock edge) form one batch, with idle cycles allowed between them; their average is the floor of their sum divided by 8.
- R2: The corrected value is floor(avg × 1000000 / (1000000 + 13 × avg)).
- R3: A trim word supplies a calibration point only when its bit 31 is 1, and the point is then its bits 11:0. If `trim_hi` bit 31 is 0 the high point is 3148; if `trim_lo` bit 31 is 0 the low point is 503. Both trim words are sampled at the clock edge that accepts the eighth code.
- R4: The unrounded temperature is (corrected − low) × floor(165000 / (high − low)) − 40000, in signed millidegrees.
- R5: The reported temperature is the smallest multiple of 500 that is greater than or equal to the unrounded temperature, for negative values as well as positive ones.
- R6: `temp_vld` is a pulse one cycle wide; `temp_mc` changes only in a cycle where `temp_vld` is high and holds its value in every other cycle.
- R7: `busy` is high from the cycle after the eighth code is accepted until the cycle in which `temp_vld` rises, when it falls; codes offered while `busy` is high are dropped and do not enter any batch.
- R8: If high ≤ low, `cal_err` pulses for one cycle after the eighth code, `temp_vld` stays low, `temp_mc` keeps its value and `busy` stays low.
- R9: After reset `busy`, `temp_vld` and `cal_err` are 0, `temp_mc` is 0 and the batch count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_vld | input | 1 | Sensor code strobe |
| code | input | 12 | Raw sensor code |
| trim_hi | input | 32 | Trim word for the high calibration point (bit 31 valid, bits 11:0 value) |
| trim_lo | input | 32 | Trim word for the low calibration point (bit 31 valid, bits 11:0 value) |
| busy | output | 1 | Conversion in progress; codes are dropped |
| temp_vld | output | 1 | One-cycle pulse marking a new temperature |
| temp_mc | output | 32 | Signed temperature in millidegrees Celsius |
| cal_err | output | 1 | One-cycle pulse: calibration points unusable |

## Verification
The checker watches on every cycle that a result pulse lasts one cycle, that the temperature register moves only with that pulse, that each published value sits on the 500 millidegree grid, that `busy` ends only with a result, and that an error pulse never coincides with a result or with a busy block. The arithmetic itself (the averaging, the curvature division, the slope quotient, the default trim fallback and the upward rounding of negative values) can only be shown by the bench's batches compared against its own model and against hand-computed values. The same holds for dropping codes during a conversion, since only the following result can reveal a code that slipped in.

// File: rtl/tj_pkg.sv
package tj_pkg;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] CORR_SCALE = 32'd1000000;
  localparam logic [DW-1:0] CORR_COEF  = 32'd13;
  localparam logic [DW-1:0] SPAN_MC    = 32'd165000;
  localparam logic [DW-1:0] OFFSET_MC  = 32'd40000;
  localparam logic [DW-1:0] GRAN_MC    = 32'd500;
  // multiple of GRAN_MC that lifts every reachable temperature above zero
  localparam logic [DW-1:0] ROUND_BIAS = 32'd1000000000;

  localparam int unsigned DEF_CAL_HI = 3148;
  localparam int unsigned DEF_CAL_LO = 503;
  localparam int unsigned TRIM_VALID_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORR,
    ST_SLOPE,
    ST_MULT,
    ST_ROUND
  } conv_state_t;
endpackage

// File: rtl/tj_sample_avg.sv
module tj_sample_avg #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned NSAMP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  output logic              batch_done,
  output logic [CODE_W-1:0] avg
);
  localparam int unsigned CNT_W = $clog2(NSAMP);
  localparam int unsigned SUM_W = CODE_W + CNT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [SUM_W-1:0] sum_inc;
  logic             last;

  assign sum_inc    = sum_q + SUM_W'(code);
  assign last       = (cnt_q == CNT_W'(NSAMP - 1));
  assign batch_done = take & last;
  assign avg        = CODE_W'(sum_inc >> CNT_W);

  always_comb begin
    cnt_d = cnt_q;
    sum_d = sum_q;
    if (take) begin
      if (last) begin
        cnt_d = '0;
        sum_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        sum_d = sum_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      sum_q <= sum_d;
    end
  end
endmodule

// File: rtl/tj_trim_sel.sv
module tj_trim_sel #(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned DEF_VAL = 0
) (
  input  logic [31:0]       trim,
  output logic [CODE_W-1:0] cal
);
  logic unused_bits;
  assign unused_bits = ^trim[30:CODE_W];

  assign cal = trim[tj_pkg::TRIM_VALID_BIT] ? trim[CODE_W-1:0] : CODE_W'(DEF_VAL);
endmodule

// File: rtl/tj_seq_div.sv
module tj_seq_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, den_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (!trial[W]) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/tj_convert.sv
module tj_convert #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned NSAMP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_vld,
  input  logic [CODE_W-1:0] code,
  input  logic [31:0]       trim_hi,
  input  logic [31:0]       trim_lo,
  output logic              busy,
  output logic              temp_vld,
  output logic [31:0]       temp_mc,
  output logic              cal_err
);
  import tj_pkg::*;

  conv_state_t state_q, state_d;

  logic              take;
  logic              batch_done;
  logic [CODE_W-1:0] avg;
  logic [CODE_W-1:0] cal_hi_w, cal_lo_w;
  logic [CODE_W-1:0] cal_hi_q, cal_hi_d;
  logic [CODE_W-1:0] cal_lo_q, cal_lo_d;
  logic [DW-1:0]     corr_q, corr_d;
  logic [DW-1:0]     slope_q, slope_d;
  logic [DW-1:0]     val_q, val_d;
  logic [DW-1:0]     temp_q, temp_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;
  logic              dstart_q, dstart_d;
  logic [DW-1:0]     dnum_q, dnum_d;
  logic [DW-1:0]     dden_q, dden_d;
  logic              ddone;
  logic [DW-1:0]     dquo, drem;
  logic signed [DW-1:0] diff_w, val_w;

  assign take = code_vld & (state_q == ST_IDLE);

  tj_sample_avg #(.CODE_W(CODE_W), .NSAMP(NSAMP)) u_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .code       (code),
    .batch_done (batch_done),
    .avg        (avg)
  );

  tj_trim_sel #(.CODE_W(CODE_W), .DEF_VAL(DEF_CAL_HI)) u_trim_hi (
    .trim (trim_hi),
    .cal  (cal_hi_w)
  );

  tj_trim_sel #(.CODE_W(CODE_W), .DEF_VAL(DEF_CAL_LO)) u_trim_lo (
    .trim (trim_lo),
    .cal  (cal_lo_w)
  );

  tj_seq_div #(.W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dstart_q),
    .num   (dnum_q),
    .den   (dden_q),
    .done  (ddone),
    .quo   (dquo),
    .rem   (drem)
  );

  // two-point line before rounding; operands are far below the 32-bit limits
  assign diff_w = $signed(corr_q) - $signed(DW'(cal_lo_q));
  assign val_w  = diff_w * $signed(slope_q) - $signed(OFFSET_MC);

  always_comb begin
    state_d  = state_q;
    cal_hi_d = cal_hi_q;
    cal_lo_d = cal_lo_q;
    corr_d   = corr_q;
    slope_d  = slope_q;
    val_d    = val_q;
    temp_d   = temp_q;
    vld_d    = 1'b0;
    err_d    = 1'b0;
    dstart_d = 1'b0;
    dnum_d   = dnum_q;
    dden_d   = dden_q;
    unique case (state_q)
      ST_IDLE: begin
        if (batch_done) begin
          cal_hi_d = cal_hi_w;
          cal_lo_d = cal_lo_w;
          if (cal_hi_w <= cal_lo_w) begin
            err_d = 1'b1;
          end else begin
            state_d  = ST_CORR;
            dstart_d = 1'b1;
            dnum_d   = DW'(avg) * CORR_SCALE;
            dden_d   = CORR_SCALE + DW'(avg) * CORR_COEF;
          end
        end
      end
      ST_CORR: begin
        if (ddone) begin
          corr_d   = dquo;
          state_d  = ST_SLOPE;
          dstart_d = 1'b1;
          dnum_d   = SPAN_MC;
          dden_d   = DW'(cal_hi_q) - DW'(cal_lo_q);
        end
      end
      ST_SLOPE: begin
        if (ddone) begin
          slope_d = dquo;
          state_d = ST_MULT;
        end
      end
      ST_MULT: begin
        val_d    = val_w;
        state_d  = ST_ROUND;
        dstart_d = 1'b1;
        dnum_d   = val_w + ROUND_BIAS;
        dden_d   = GRAN_MC;
      end
      ST_ROUND: begin
        if (ddone) begin
          temp_d  = (drem == '0) ? val_q : val_q + (GRAN_MC - drem);
          vld_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cal_hi_q <= '0;
      cal_lo_q <= '0;
      corr_q   <= '0;
      slope_q  <= '0;
      val_q    <= '0;
      temp_q   <= '0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
      dstart_q <= 1'b0;
      dnum_q   <= '0;
      dden_q   <= '0;
    end else begin
      state_q  <= state_d;
      cal_hi_q <= cal_hi_d;
      cal_lo_q <= cal_lo_d;
      corr_q   <= corr_d;
      slope_q  <= slope_d;
      val_q    <= val_d;
      temp_q   <= temp_d;
      vld_q    <= vld_d;
      err_q    <= err_d;
      dstart_q <= dstart_d;
      dnum_q   <= dnum_d;
      dden_q   <= dden_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign temp_vld = vld_q;
  assign temp_mc  = temp_q;
  assign cal_err  = err_q;
endmodule

// File: rtl/tj_convert_checker.sv
module tj_convert_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        temp_vld,
  input logic [31:0] temp_mc,
  input logic        cal_err
);
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    temp_vld |=> !temp_vld); // R6

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_vld |-> $stable(temp_mc)); // R6

  AST_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    temp_vld |-> (($signed(temp_mc) % 32'sd500) == 32'sd0)); // R5

  AST_BUSY_ENDS_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> temp_vld); // R7

  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> (!temp_vld && !busy)); // R8

  AST_ERR_KEEPS_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> $stable(temp_mc)); // R8
endmodule

bind tj_convert tj_convert_checker u_tj_convert_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .temp_vld (temp_vld),
  .temp_mc  (temp_mc),
  .cal_err  (cal_err)
);

// File: tb/test_tj_convert.sv
module test_tj_convert;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        code_vld;
  logic [11:0] code;
  logic [31:0] trim_hi;
  logic [31:0] trim_lo;
  logic        busy;
  logic        temp_vld;
  logic [31:0] temp_mc;
  logic        cal_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  tj_convert i_tj_convert (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_vld (code_vld),
    .code     (code),
    .trim_hi  (trim_hi),
    .trim_lo  (trim_lo),
    .busy     (busy),
    .temp_vld (temp_vld),
    .temp_mc  (temp_mc),
    .cal_err  (cal_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model built from R1..R5
  function automatic void model(input longint sum, input logic [31:0] th, input logic [31:0] tl,
                                output bit err, output longint res);
    longint avg, corr, hi, lo, q, v, m;
    avg  = sum / 8;
    corr = (avg * 1000000) / (1000000 + avg * 13);
    hi   = th[31] ? longint'(th[11:0]) : 3148;
    lo   = tl[31] ? longint'(tl[11:0]) : 503;
    err  = (hi <= lo);
    res  = 0;
    if (!err) begin
      q   = 165000 / (hi - lo);
      v   = (corr - lo) * q - 40000;
      m   = ((v % 500) + 500) % 500;
      res = (m == 0) ? v : v + 500 - m;
    end
  endfunction

  task automatic run_batch(input logic [11:0] c[8], input logic [31:0] th, input logic [31:0] tl,
                           input bit gaps, input bit noise, input string tag,
                           input bit has_fix, input longint fix);
    longint sum;
    bit     exp_err;
    longint exp_res;
    logic [31:0] prev;
    bit     seen;
    sum = 0;
    for (int i = 0; i < 8; i++) sum += longint'(c[i]);
    model(sum, th, tl, exp_err, exp_res);
    prev    = temp_mc;
    trim_hi = th;
    trim_lo = tl;
    for (int i = 0; i < 8; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        code_vld = 1'b0;
        code     = 12'($urandom);
        @(negedge clk);
      end
      code_vld = 1'b1;
      code     = c[i];
      @(negedge clk);
    end
    code_vld = 1'b0;
    if (!exp_err) chk(busy == 1'b1, {"R7 busy after batch ", tag}, longint'(busy), 1);
    seen = 0;
    for (int n = 0; n < 400 && !seen; n++) begin
      if (temp_vld || cal_err) begin
        seen = 1;
      end else begin
        if (noise && busy) begin
          code_vld = 1'b1;
          code     = 12'($urandom);
        end
        @(negedge clk);
        code_vld = 1'b0;
      end
    end
    code_vld = 1'b0;
    if (exp_err) begin
      chk(cal_err == 1'b1, {"R8 error pulse ", tag}, longint'(cal_err), 1);
      chk(temp_vld == 1'b0 && temp_mc == prev, {"R8 output held ", tag},
          longint'($signed(temp_mc)), longint'($signed(prev)));
      @(negedge clk);
      chk(cal_err == 1'b0 && busy == 1'b0 && temp_vld == 1'b0, {"R8 single pulse idle ", tag},
          longint'({cal_err, busy, temp_vld}), 0);
    end else begin
      chk(temp_vld == 1'b1, {"R6 result pulse ", tag}, longint'(temp_vld), 1);
      chk(longint'($signed(temp_mc)) == exp_res, {"R1 R2 R3 R4 R5 value ", tag},
          longint'($signed(temp_mc)), exp_res);
      if (has_fix)
        chk(longint'($signed(temp_mc)) == fix, {"R5 hand value ", tag},
            longint'($signed(temp_mc)), fix);
      if (noise)
        chk(longint'($signed(temp_mc)) == exp_res, {"R7 busy codes dropped ", tag},
            longint'($signed(temp_mc)), exp_res);
      prev = temp_mc;
      @(negedge clk);
      chk(temp_vld == 1'b0 && temp_mc == prev && busy == 1'b0, {"R6 pulse ends and holds ", tag},
          longint'(temp_vld), 0);
    end
  endtask

  task automatic fill(output logic [11:0] c[8], input logic [11:0] v);
    for (int i = 0; i < 8; i++) c[i] = v;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] c[8];
    logic [31:0] th, tl;
    logic [11:0] a, b;
    void'($urandom(32'd1234));
    rst_n    = 1'b0;
    code_vld = 1'b0;
    code     = '0;
    trim_hi  = '0;
    trim_lo  = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 0 && temp_vld == 0 && cal_err == 0, "R9 reset flags", longint'({busy, temp_vld, cal_err}), 0);
    chk(temp_mc == 32'd0, "R9 reset temperature", longint'(temp_mc), 0);
    // code offered during reset must not start a batch
    code_vld = 1'b1;
    code     = 12'd4095;
    @(negedge clk);
    code_vld = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);

    // defaults, avg 1000: corr 987, slope 62, -9992 -> -9500 (R2 R3 R4 R5)
    fill(c, 12'd1000);
    run_batch(c, 32'h0, 32'h0, 0, 0, "avg1000 defaults", 1, -9500);
    // zero codes: -71186 -> -71000 (R5 negative)
    fill(c, 12'd0);
    run_batch(c, 32'h0, 32'h0, 0, 0, "zero codes", 1, -71000);
    // full-scale codes, defaults
    fill(c, 12'd4095);
    run_batch(c, 32'h0, 32'h0, 0, 0, "full scale", 0, 0);
    // R1 floor of average: sum 8*2000+7 -> avg 2000
    fill(c, 12'd2000);
    c[0] = 12'd2007;
    run_batch(c, 32'h0, 32'h0, 1, 0, "R1 floor average", 0, 0);
    // R3: bit 31 clear with value bits set -> defaults used
    fill(c, 12'd1000);
    run_batch(c, 32'h0000_0FFF, 32'h7FFF_F001, 0, 0, "R3 invalid trims ignored", 1, -9500);
    // R3: valid trims; hi=3000 lo=500 q=66: (987-500)*66-40000=-7858 -> -7500
    run_batch(c, 32'h8000_0BB8, 32'h8000_01F4, 0, 0, "R3 valid trims", 1, -7500);
    // R5 exact multiple: hi=665 lo=500 q=1000, corr 987: 487000-40000=447000
    run_batch(c, 32'h8000_0299, 32'h8000_01F4, 0, 0, "R5 exact grid", 1, 447000);
    // R8 equal points
    run_batch(c, 32'h8000_0200, 32'h8000_0200, 0, 0, "R8 equal points", 0, 0);
    // R8 high below low
    run_batch(c, 32'h8000_0100, 32'h0, 0, 0, "R8 high below low", 0, 0);
    // R7 noisy codes during conversion
    fill(c, 12'd1500);
    run_batch(c, 32'h0, 32'h0, 0, 1, "R7 noise", 0, 0);

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 8; i++) c[i] = 12'($urandom);
      a = 12'($urandom);
      b = 12'($urandom);
      if (a < b) begin
        th = {1'b1, 19'($urandom), b};
        tl = {1'b1, 19'($urandom), a};
      end else begin
        th = {1'b1, 19'($urandom), a};
        tl = {1'b1, 19'($urandom), b};
      end
      if ($urandom % 5 == 0) th[31] = 1'b0;
      if ($urandom % 5 == 0) tl[31] = 1'b0;
      run_batch(c, th, tl, 1, ($urandom % 2) == 1, $sformatf("random %0d", k), 0, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule